// File: doc/BRIEF.md
# Linear image sensor readout sequencer

This block runs on a fast system clock and drives a serial-scan linear photodiode array with NPIX pixels. It makes the sensor clock by dividing the system clock, and it issues the one-clock start pulse that begins each scan. The scan lasts NPIX+1 sensor clocks. The last of those edges only returns the sensor to rest and carries no pixel. After each sensor rising edge that brings out a pixel, the block waits a fixed settling time. It then strobes an external converter and gives the zero-based pixel index with start-of-frame and end-of-frame flags.

The gap between consecutive start pulses is the exposure time of the array, so the same sequencer also sets integration. In single-shot mode, one start request gives one scan, and the sensor clock then stops low. In continuous mode, scans repeat with a start-to-start spacing equal to the programmed period in sensor clocks. That spacing never falls below the earliest legal restart, which is one clock after the terminating edge.

Top module: `linscan_seq`

## Requirements
- R1: While reset is held and right after it is released, sen_clk, sen_si, adc_go, frame_first, frame_last and frame_done are low, and pix_idx is 0.
- R2: Each high phase and each low phase of sen_clk inside a scan lasts exactly H system cycles, where H = max(half_div, MIN_HALF). With the defaults, a half_div of 5 gives H = 13.
- R3: sen_si is high at exactly one rising edge of sen_clk per scan. It changes only while sen_clk is low, and it is high for at least H-1 system cycles before the edge that captures it.
- R4: After sen_clk rising edge k of a scan, for k = 1..NPIX, adc_go is high for one system cycle exactly SETTLE_CYC system cycles later, with pix_idx = k-1. Each scan gives NPIX strobes in increasing index order.
- R5: frame_first is high only together with the strobe for index 0, and frame_last only together with the strobe for index NPIX-1. Both are low in every other cycle.
- R6: In single-shot mode a scan has exactly NPIX+1 rising edges of sen_clk. frame_done pulses for one cycle, one system cycle after rising edge NPIX+1. The clock then stays low until the next start.
- R7: In continuous mode the number of sen_clk rising edges from one captured start to the next is max(int_period, NPIX+1). The second start is therefore captured on edge NPIX+2 at the earliest.
- R8: Clearing cont_mode before edge NPIX+1 ends the run after that edge. Clearing it during the gap ends the run after edge max(int_period, NPIX+1). In both cases no further start pulse is sent.
- R9: A start request while a scan is running is ignored: it causes no extra sen_si pulse and no extra scan.
- R10: half_div is sampled only when the clock starts from rest. A change during a scan leaves that scan's phase lengths unchanged and applies to the next scan started from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | Requested sensor clock half-period in system cycles |
| int_period | input | INT_W | Start-to-start spacing in sensor clocks (continuous mode) |
| start | input | 1 | One-cycle request to begin a scan from idle |
| cont_mode | input | 1 | 1: repeat scans; 0: stop after the current scan |
| sen_clk | output | 1 | Clock to the sensor array |
| sen_si | output | 1 | Scan start pulse to the sensor array |
| adc_go | output | 1 | One-cycle converter strobe after the output has settled |
| pix_idx | output | IDX_W | Zero-based index of the strobed pixel |
| frame_first | output | 1 | High with the strobe of pixel 0 |
| frame_last | output | 1 | High with the strobe of pixel NPIX-1 |
| frame_done | output | 1 | One-cycle pulse after the terminating sensor edge |

## Verification
The assertions assume that start, cont_mode, half_div and int_period are driven synchronously to clk. They also assume that reset holds long enough for every register to settle. They do not assume that inputs stay constant during a scan, because the block itself must ignore starts and latch the divider. The stimulus changes inputs half a system cycle after the active edge. It deliberately pulses start and alters half_div in the middle of a scan. It clears cont_mode both before the terminating edge and in the gap after it, so that the ignoring, latching and stopping rules are all exercised without any setup race.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_SCAN = 2'd2,
      ST_STOP = 2'd3
   } seq_st_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lsq_clkgen.sv
module lsq_clkgen #(
   parameter int DIV_W    = 8,
   parameter int MIN_HALF = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] half_i,
   output logic             sck_o,
   output logic             rise_o,
   output logic             fall_o,
   output logic             stopped_o
);

   localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] half_q;
   logic [DIV_W-1:0] half_eff;
   logic             active;

   assign half_eff  = (half_i < MIN_H) ? MIN_H : half_i;
   assign stopped_o = !active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         half_q <= MIN_H;
         active <= 1'b0;
         sck_o  <= 1'b0;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
      end else begin
         rise_o <= 1'b0;
         fall_o <= 1'b0;
         if (!active) begin
            cnt <= '0;
            if (run_i) begin
               active <= 1'b1;
               half_q <= half_eff;
            end
         end else if (cnt == half_q - 1'b1) begin
            cnt    <= '0;
            sck_o  <= !sck_o;
            rise_o <= !sck_o;
            fall_o <= sck_o;
            if (sck_o && !run_i) active <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // phase-length watch, separate from the divider counter
   logic             sck_d;
   logic [DIV_W:0]   plen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         plen  <= '0;
      end else begin
         sck_d <= sck_o;
         if (sck_o != sck_d)   plen <= (DIV_W+1)'(1);
         else if (plen != '1) plen <= plen + 1'b1;
      end
   end

   // R2
   phase_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_o != sck_d) |-> (plen >= (DIV_W+1)'(MIN_HALF)));

   // R6
   run_drop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_i) |-> sck_o);

endmodule

// File: rtl/lsq_seq.sv
module lsq_seq
   import lsq_pkg::*;
#(
   parameter int NPIX  = 512,
   parameter int INT_W = 20,
   parameter int CNT_W = 20,
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cont_i,
   input  logic [INT_W-1:0] period_i,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic             stopped_i,
   output logic             run_o,
   output logic             si_o,
   output logic             done_o,
   output logic             pvalid_o,
   output logic [IDX_W-1:0] pidx_o
);

   localparam int             SCAN_LEN = NPIX + 1;
   localparam logic [CNT_W-1:0] SL_C   = CNT_W'(SCAN_LEN);
   localparam logic [CNT_W-1:0] NP_C   = CNT_W'(NPIX);

   seq_st_t          st;
   logic [CNT_W-1:0] ecnt;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] per_ext;
   logic [CNT_W-1:0] per_eff;
   logic [CNT_W-1:0] ecnt_nx;
   logic             go_next;
   logic             scanning;

   assign per_ext  = CNT_W'(period_i);
   assign per_eff  = (per_ext < SL_C) ? SL_C : per_ext;
   assign ecnt_nx  = si_o ? CNT_W'(1) : ecnt + 1'b1;
   assign scanning = (st == ST_ARM) || (st == ST_SCAN);
   assign pvalid_o = rise_i && scanning && (ecnt_nx <= NP_C);
   assign pidx_o   = IDX_W'(ecnt_nx - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ecnt    <= '0;
         per_q   <= SL_C;
         go_next <= 1'b0;
         si_o    <= 1'b0;
         run_o   <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start_i) begin
                  si_o    <= 1'b1;
                  run_o   <= 1'b1;
                  per_q   <= per_eff;
                  go_next <= 1'b0;
                  st      <= ST_ARM;
               end
            end
            ST_ARM, ST_SCAN: begin
               if (rise_i) begin
                  ecnt <= ecnt_nx;
                  st   <= ST_SCAN;
                  if (ecnt_nx == SL_C) done_o <= 1'b1;
                  if (ecnt_nx == SL_C && !cont_i) begin
                     run_o <= 1'b0;
                     st    <= ST_STOP;
                  end else if (ecnt_nx == per_q) begin
                     if (cont_i) begin
                        go_next <= 1'b1;
                     end else begin
                        run_o <= 1'b0;
                        st    <= ST_STOP;
                     end
                  end
               end
               if (fall_i) begin
                  if (go_next) begin
                     si_o    <= 1'b1;
                     per_q   <= per_eff;
                     go_next <= 1'b0;
                  end else begin
                     si_o <= 1'b0;
                  end
               end
            end
            default: begin
               go_next <= 1'b0;
               if (stopped_i) st <= ST_IDLE;
            end
         endcase
      end
   end

   // independent record of start captures for the checks below
   logic             prev_rise_si;
   logic             cap_seen;
   logic [CNT_W:0]   since_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_rise_si <= 1'b0;
         cap_seen     <= 1'b0;
         since_cap    <= '0;
      end else if (rise_i) begin
         prev_rise_si <= si_o;
         if (si_o) begin
            cap_seen  <= 1'b1;
            since_cap <= (CNT_W+1)'(1);
         end else if (since_cap != '1) begin
            since_cap <= since_cap + 1'b1;
         end
      end
   end

   // R3
   si_one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && si_o) |-> !prev_rise_si);

   // R7
   si_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && si_o && cap_seen) |-> (since_cap >= (CNT_W+1)'(SCAN_LEN)));

endmodule

// File: rtl/lsq_strobe.sv
module lsq_strobe #(
   parameter int NPIX       = 512,
   parameter int IDX_W      = 9,
   parameter int SETTLE_CYC = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             go_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             first_o,
   output logic             last_o
);

   localparam int               TW     = $clog2(SETTLE_CYC + 1);
   localparam logic [IDX_W-1:0] LAST_I = IDX_W'(NPIX - 1);

   logic [TW-1:0]    tmr;
   logic             pend;
   logic [IDX_W-1:0] idx_hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr      <= '0;
         pend     <= 1'b0;
         idx_hold <= '0;
         go_o     <= 1'b0;
         idx_o    <= '0;
         first_o  <= 1'b0;
         last_o   <= 1'b0;
      end else begin
         go_o    <= 1'b0;
         first_o <= 1'b0;
         last_o  <= 1'b0;
         if (load_i) begin
            tmr      <= TW'(SETTLE_CYC - 1);
            idx_hold <= idx_i;
            pend     <= 1'b1;
         end else if (pend) begin
            if (tmr == TW'(1)) begin
               go_o    <= 1'b1;
               idx_o   <= idx_hold;
               first_o <= (idx_hold == '0);
               last_o  <= (idx_hold == LAST_I);
               pend    <= 1'b0;
            end else begin
               tmr <= tmr - 1'b1;
            end
         end
      end
   end

   logic [TW:0]      since_ld;
   logic [IDX_W-1:0] prev_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_ld <= '1;
         prev_idx <= '0;
      end else begin
         if (load_i)              since_ld <= (TW+1)'(1);
         else if (since_ld != '1) since_ld <= since_ld + 1'b1;
         if (go_o) prev_idx <= idx_o;
      end
   end

   // R4
   settle_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_o |-> (since_ld == (TW+1)'(SETTLE_CYC)));

   // R4
   pix_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_o && idx_o != '0) |-> (idx_o == IDX_W'(prev_idx + 1'b1)));

endmodule

// File: rtl/linscan_seq.sv
module linscan_seq
   import lsq_pkg::*;
#(
   parameter int NPIX       = 512,
   parameter int DIV_W      = 8,
   parameter int MIN_HALF   = 13,
   parameter int SETTLE_CYC = 24,
   parameter int INT_W      = 20,
   parameter int IDX_W      = $clog2(NPIX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_div,
   input  logic [INT_W-1:0] int_period,
   input  logic             start,
   input  logic             cont_mode,
   output logic             sen_clk,
   output logic             sen_si,
   output logic             adc_go,
   output logic [IDX_W-1:0] pix_idx,
   output logic             frame_first,
   output logic             frame_last,
   output logic             frame_done
);

   localparam int SL_W  = $clog2(NPIX + 2);
   localparam int CNT_W = imax(INT_W, SL_W);

   generate
      if (NPIX < 2) begin : g_bad_npix
         $error("NPIX must be at least 2");
      end
      if (SETTLE_CYC < 2) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 2");
      end
      if (SETTLE_CYC >= 2 * MIN_HALF) begin : g_bad_window
         $error("SETTLE_CYC must be shorter than one sensor clock period");
      end
      if (MIN_HALF >= (1 << DIV_W)) begin : g_bad_div
         $error("MIN_HALF does not fit in DIV_W bits");
      end
      if (IDX_W < $clog2(NPIX)) begin : g_bad_idx
         $error("IDX_W too narrow for NPIX");
      end
   endgenerate

   logic             run;
   logic             rise;
   logic             fall;
   logic             stopped;
   logic             pvalid;
   logic [IDX_W-1:0] pidx;

   lsq_clkgen #(
      .DIV_W    (DIV_W),
      .MIN_HALF (MIN_HALF)
   ) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .half_i    (half_div),
      .sck_o     (sen_clk),
      .rise_o    (rise),
      .fall_o    (fall),
      .stopped_o (stopped)
   );

   lsq_seq #(
      .NPIX  (NPIX),
      .INT_W (INT_W),
      .CNT_W (CNT_W),
      .IDX_W (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .cont_i    (cont_mode),
      .period_i  (int_period),
      .rise_i    (rise),
      .fall_i    (fall),
      .stopped_i (stopped),
      .run_o     (run),
      .si_o      (sen_si),
      .done_o    (frame_done),
      .pvalid_o  (pvalid),
      .pidx_o    (pidx)
   );

   lsq_strobe #(
      .NPIX       (NPIX),
      .IDX_W      (IDX_W),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_stb (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (pvalid),
      .idx_i   (pidx),
      .go_o    (adc_go),
      .idx_o   (pix_idx),
      .first_o (frame_first),
      .last_o  (frame_last)
   );

   // R3
   si_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sen_si != $past(sen_si)) |-> !sen_clk);

endmodule

// File: tb/sim_linscan_seq.sv
`timescale 1ns/1ps
module sim_linscan_seq;

   localparam int NPIX   = 512;
   localparam int MINH   = 13;
   localparam int SETTLE = 24;
   localparam int WDOG   = 195000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] half_div = 8'd13;
   logic [19:0] int_period = '0;
   logic       start = 1'b0;
   logic       cont_mode = 1'b0;
   logic       sen_clk, sen_si, adc_go, frame_first, frame_last, frame_done;
   logic [8:0] pix_idx;

   always #4 clk = !clk;

   linscan_seq u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .half_div    (half_div),
      .int_period  (int_period),
      .start       (start),
      .cont_mode   (cont_mode),
      .sen_clk     (sen_clk),
      .sen_si      (sen_si),
      .adc_go      (adc_go),
      .pix_idx     (pix_idx),
      .frame_first (frame_first),
      .frame_last  (frame_last),
      .frame_done  (frame_done)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor, sampled on the falling system edge
   int cyc = 0;
   bit sck_q = 0, si_q = 0, prev_rise_si = 0;
   int last_tog = 0, last_rise = 0, si_rose_cyc = 0, last_hi_len = 0;
   int rise_since = 0, nrise = 0, si_caps = 0, last_spacing = 0;
   int strobes = 0, firsts = 0, lasts = 0, done_cnt = 0, nxt_idx = 0;
   int exp_half = MINH;

   always @(negedge clk) begin
      cyc++;
      if (cyc >= WDOG && !finished) begin
         chk(0, "watchdog", cyc, WDOG);
         summary();
      end
      if (rst_n) begin
         if (sen_si && !si_q) si_rose_cyc = cyc;
         if (sen_clk != sck_q) begin
            if (!sen_clk) begin
               last_hi_len = cyc - last_tog;
               chk(last_hi_len == exp_half, "R2 high phase", last_hi_len, exp_half);
            end else begin
               nrise++;
               if (!sen_si)
                  chk(cyc - last_tog == exp_half, "R2 low phase", cyc - last_tog, exp_half);
               if (sen_si) begin
                  chk(!prev_rise_si, "R3 single capture", prev_rise_si, 0);
                  chk(cyc - si_rose_cyc >= exp_half - 1, "R3 setup", cyc - si_rose_cyc, exp_half - 1);
                  if (si_caps > 0) last_spacing = rise_since;
                  si_caps++;
                  rise_since = 1;
                  nxt_idx = 0;
               end else begin
                  rise_since++;
               end
               prev_rise_si = sen_si;
               last_rise = cyc;
            end
            last_tog = cyc;
         end
         if (adc_go) begin
            chk(cyc - last_rise == SETTLE, "R4 settle", cyc - last_rise, SETTLE);
            chk(int'(pix_idx) == nxt_idx, "R4 index", int'(pix_idx), nxt_idx);
            chk(frame_first == (nxt_idx == 0), "R5 first", frame_first, nxt_idx == 0);
            chk(frame_last == (nxt_idx == NPIX - 1), "R5 last", frame_last, nxt_idx == NPIX - 1);
            if (frame_first) firsts++;
            if (frame_last) lasts++;
            nxt_idx++;
            strobes++;
         end else if (frame_first || frame_last) begin
            chk(0, "R5 flag without strobe", 1, 0);
         end
         if (frame_done) begin
            chk(rise_since == NPIX + 1, "R6 done edge", rise_since, NPIX + 1);
            chk(cyc - last_rise == 1, "R6 done delay", cyc - last_rise, 1);
            done_cnt++;
         end
      end
      sck_q = sen_clk;
      si_q  = sen_si;
   end

   task automatic pulse_start();
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
   endtask

   task automatic wait_quiet();
      while (cyc - last_tog < 4 * exp_half + 10) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!sen_clk && !sen_si && !adc_go && !frame_done, "R1 outputs", sen_clk, 0);
      chk(pix_idx == '0 && !frame_first && !frame_last, "R1 index", int'(pix_idx), 0);
   endtask

   task automatic t_single(input int hd);
      int c0, s0, f0, l0, d0, r0;
      half_div = 8'(hd);
      exp_half = (hd < MINH) ? MINH : hd;
      c0 = si_caps; s0 = strobes; f0 = firsts; l0 = lasts; d0 = done_cnt;
      pulse_start();
      while (done_cnt == d0) @(negedge clk);
      wait_quiet();
      chk(si_caps == c0 + 1, "R3 one start per scan", si_caps - c0, 1);
      chk(strobes - s0 == NPIX, "R4 strobe count", strobes - s0, NPIX);
      chk(firsts - f0 == 1 && lasts - l0 == 1, "R5 flag count", firsts - f0, 1);
      chk(rise_since == NPIX + 1, "R6 edges per scan", rise_since, NPIX + 1);
      r0 = nrise;
      repeat (300) @(negedge clk);
      chk(nrise == r0 && !sen_clk, "R6 clock held low", nrise - r0, 0);
   endtask

   task automatic t_hold();
      int c0, d0, r0;
      half_div = 8'd13;
      exp_half = 13;
      c0 = si_caps; d0 = done_cnt;
      pulse_start();
      while (rise_since < 100 || si_caps == c0) @(negedge clk);
      half_div = 8'd16;
      pulse_start();
      while (done_cnt == d0) @(negedge clk);
      wait_quiet();
      chk(si_caps == c0 + 1, "R9 no extra start", si_caps - c0, 1);
      chk(rise_since == NPIX + 1, "R9 no restart", rise_since, NPIX + 1);
      chk(last_hi_len == 13, "R10 divider held", last_hi_len, 13);
      r0 = nrise;
      repeat (300) @(negedge clk);
      chk(nrise == r0, "R9 stays idle", nrise - r0, 0);
   endtask

   task automatic t_cont(input int hd, input int ip, input int stop_at, input int exp_end);
      int c0, s0, per;
      half_div = 8'(hd);
      exp_half = (hd < MINH) ? MINH : hd;
      per = (ip < NPIX + 1) ? NPIX + 1 : ip;
      int_period = 20'(ip);
      cont_mode = 1'b1;
      c0 = si_caps; s0 = strobes;
      pulse_start();
      while (si_caps < c0 + 3) @(negedge clk);
      chk(last_spacing == per, "R7 start spacing", last_spacing, per);
      chk(last_hi_len == exp_half, "R10 new divider", last_hi_len, exp_half);
      while (rise_since < stop_at) @(negedge clk);
      cont_mode = 1'b0;
      wait_quiet();
      chk(rise_since == exp_end, "R8 final edge", rise_since, exp_end);
      chk(si_caps == c0 + 3 && !sen_clk, "R8 no further start", si_caps - c0, 3);
      chk(strobes - s0 == 3 * NPIX, "R4 strobes over run", strobes - s0, 3 * NPIX);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single(5);
      t_hold();
      t_cont(16, 100, 10, NPIX + 1);
      t_cont(13, 600, 530, 600);
      summary();
   end

endmodule